// File: doc/BRIEF.md
# UART Interrupt Enable and Priority Encoder

This block handles interrupt masking and source identification for one serial channel. Four condition sources feed it:

- receive line errors;
- received data ready;
- transmit holding empty;
- modem input changes.

A host-written enable register masks each source. The block raises a single interrupt line while any unmasked source is pending. It presents an identification value that names the most urgent pending source.

The receive and transmit conditions depend on the buffering mode. With buffering off, receive-ready means the holding register has a byte. Transmit-empty means the holding register is empty. With buffering on, receive-ready compares the receive fill level against a programmable trigger. Transmit-empty then needs both the transmit buffer and the holding register to be empty.

The transmit-empty interrupt is an event, not a level. It is latched when its enabled condition starts. It clears when the host reads the identification value while that value names it, or when the host writes the transmit holding register. The other three sources follow their status inputs directly.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00. A write stores data bits 3..0, and bits 7..4 always read 0. Bit 0 gates receive-ready, bit 1 gates transmit-empty, bit 2 gates line errors and bit 3 gates modem changes.
- R2: The line-error source is pending while enable bit 2 is 1 and any bit of `line_err` is 1. It has the highest priority, and its identification is `irq_id` = 4'b0110.
- R3: `irq_id[0]` is 1 when no source is pending, and then `irq_id` = 4'b0001. `irq_id[3:1]` holds the code of the reported source. `irq` is 1 exactly when at least one source is pending.
- R4: The modem source is pending while enable bit 3 is 1 and any bit of `modem_delta` is 1. It has the lowest priority, and its identification is 4'b0000.
- R5: With `fifo_mode`=0, the receive source is pending while enable bit 0 is 1 and `rx_level` is nonzero. Its identification is 4'b0100.
- R6: The transmit condition is `thr_empty` with `fifo_mode`=0. When the condition and enable bit 1 are both true and were not both true in the previous cycle, the transmit source is pending from the next cycle on. Its identification is 4'b0010.
- R7: The transmit source clears on the edge where `iir_rd` is 1 while `irq_id` is 4'b0010. It also clears on the edge where `thr_wr` is 1, and whenever its enabled condition is false.
- R8: With `fifo_mode`=1, the transmit condition requires both `thr_empty` and `tx_fifo_empty`.
- R9: With `fifo_mode`=1, the receive source is pending while enable bit 0 is 1 and `rx_level` >= `rx_trigger`. It clears as soon as the level drops below the trigger.
- R10: When several sources are pending, only the highest-priority one is reported. The order is line errors, then receive, then transmit, then modem.
- R11: A source whose enable bit is 0 never raises `irq`, even while its condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register contents |
| fifo_mode | input | 1 | 1 selects buffered receive/transmit conditions |
| rx_level | input | 5 | Receive bytes held (holding register or buffer fill) |
| rx_trigger | input | 5 | Receive trigger level used in buffered mode |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_fifo_empty | input | 1 | Transmit buffer empty |
| line_err | input | 4 | Receive error flags (overrun, parity, framing, break) |
| modem_delta | input | 4 | Modem input change flags |
| iir_rd | input | 1 | Host read of the identification value |
| thr_wr | input | 1 | Host write of the transmit holding register |
| irq | output | 1 | Combined interrupt request |
| irq_id | output | 4 | {source code[2:0], no-pending flag} |

## Verification
A corrupted enable register shows up one cycle after the write, at `ier_rdata`. It also changes `irq` immediately for any source whose condition is present.

The transmit event state is the only hidden state beyond the enable register. A stale or lost event shows up in the next cycle as a wrong `irq_id`. Examples are a second assertion after a clearing read or write, or a missing assertion after re-arming. Sequences with several sources pending at once expose a wrong priority order on the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 4;

    // priority slots: lower index wins
    localparam int SLOT_LINE  = 0;
    localparam int SLOT_RX    = 1;
    localparam int SLOT_TX    = 2;
    localparam int SLOT_MODEM = 3;

    // enable register bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_TX    = 3'b001,
        ID_RX    = 3'b010,
        ID_LINE  = 3'b011
    } irq_id_e;

    typedef struct packed {
        logic arm;
        logic pend;
    } tx_state_t;

    function automatic irq_id_e slot_to_id(input int slot);
        case (slot)
            SLOT_LINE: return ID_LINE;
            SLOT_RX:   return ID_RX;
            SLOT_TX:   return ID_TX;
            default:   return ID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
    parameter int DATA_W  = 8,
    parameter int EN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << EN_BITS) - 1);

    typedef struct packed {
        logic [DATA_W-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.en = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.en;

    // R1
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == ($past(wdata) & KEEP_MASK)));

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int LS_W  = 4,
    parameter int MS_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         en,
    input  logic               fifo_mode,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   rx_trigger,
    input  logic               thr_empty,
    input  logic               tx_fifo_empty,
    input  logic [LS_W-1:0]    line_err,
    input  logic [MS_W-1:0]    modem_delta,
    input  logic               thr_wr,
    input  logic               rd_clr,
    output logic [NUM_SRC-1:0] src
);
    tx_state_t st_d, st_q;
    logic      rx_cond;
    logic      tx_cond;
    logic      tx_arm;

    always_comb begin
        rx_cond = fifo_mode ? (rx_level >= rx_trigger) : (rx_level != '0);
        tx_cond = fifo_mode ? (thr_empty && tx_fifo_empty) : thr_empty;
        tx_arm  = tx_cond && en[EN_TX];

        st_d     = st_q;
        st_d.arm = tx_arm;
        if (!tx_arm) begin
            st_d.pend = 1'b0;
        end else if (thr_wr || rd_clr) begin
            st_d.pend = 1'b0;
        end else if (!st_q.arm) begin
            st_d.pend = 1'b1;
        end

        src             = '0;
        src[SLOT_LINE]  = en[EN_LINE] && (|line_err);
        src[SLOT_RX]    = en[EN_RX] && rx_cond;
        src[SLOT_TX]    = st_q.pend;
        src[SLOT_MODEM] = en[EN_MODEM] && (|modem_delta);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    tx_arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_arm && !st_q.arm && !thr_wr && !rd_clr) |=> st_q.pend);

    // R7
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr || rd_clr) |=> !st_q.pend);

    // R8
    tx_fifo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && !tx_fifo_empty) |=> !st_q.pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] src,
    output logic               any,
    output irq_id_e            code
);
    always_comb begin
        any  = 1'b0;
        code = ID_MODEM;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src[i]) begin
                any  = 1'b1;
                code = slot_to_id(i);
            end
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int EN_BITS = 4,
    parameter int LVL_W   = 5,
    parameter int LS_W    = 4,
    parameter int MS_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [DATA_W-1:0] ier_wdata,
    output logic [DATA_W-1:0] ier_rdata,
    input  logic              fifo_mode,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_trigger,
    input  logic              thr_empty,
    input  logic              tx_fifo_empty,
    input  logic [LS_W-1:0]   line_err,
    input  logic [MS_W-1:0]   modem_delta,
    input  logic              iir_rd,
    input  logic              thr_wr,
    output logic              irq,
    output logic [3:0]        irq_id
);
    logic [NUM_SRC-1:0] src;
    logic               any;
    irq_id_e            code;
    logic               rd_clr;

    uart_irq_enable #(.DATA_W(DATA_W), .EN_BITS(EN_BITS)) i_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ier_wr),
        .wdata (ier_wdata),
        .rdata (ier_rdata)
    );

    uart_irq_sources #(.LVL_W(LVL_W), .LS_W(LS_W), .MS_W(MS_W)) i_sources (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (ier_rdata[3:0]),
        .fifo_mode     (fifo_mode),
        .rx_level      (rx_level),
        .rx_trigger    (rx_trigger),
        .thr_empty     (thr_empty),
        .tx_fifo_empty (tx_fifo_empty),
        .line_err      (line_err),
        .modem_delta   (modem_delta),
        .thr_wr        (thr_wr),
        .rd_clr        (rd_clr),
        .src           (src)
    );

    uart_irq_prio i_prio (
        .src  (src),
        .any  (any),
        .code (code)
    );

    assign rd_clr = iir_rd && any && (code == ID_TX);
    assign irq    = any;
    assign irq_id = {code, ~any};

    // R2
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[EN_LINE] && (|line_err)) |-> (irq_id == {ID_LINE, 1'b0}));

    // R5
    rx_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[EN_RX] && !fifo_mode && (rx_level != '0)
         && !(ier_rdata[EN_LINE] && (|line_err))) |-> (irq_id == {ID_RX, 1'b0}));

    // R11
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[3:0] == 4'b0000) |=> (!irq || $past(ier_wr)));

endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] ier_rdata;
    logic       fm = 1'b0;
    logic [4:0] rxl = '0;
    logic [4:0] rxt = 5'd4;
    logic       te = 1'b0;
    logic       tfe = 1'b0;
    logic [3:0] lse = '0;
    logic [3:0] msd = '0;
    logic       rd = 1'b0;
    logic       tw = 1'b0;
    logic       irq;
    logic [3:0] irq_id;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    typedef struct {
        logic       irq;
        logic [3:0] id;
        logic [7:0] ier;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ier_wr        (wr),
        .ier_wdata     (wd),
        .ier_rdata     (ier_rdata),
        .fifo_mode     (fm),
        .rx_level      (rxl),
        .rx_trigger    (rxt),
        .thr_empty     (te),
        .tx_fifo_empty (tfe),
        .line_err      (lse),
        .modem_delta   (msd),
        .iir_rd        (rd),
        .thr_wr        (tw),
        .irq           (irq),
        .irq_id        (irq_id)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic at_neg();
        @(negedge clk);
        wr = 1'b0;
        rd = 1'b0;
        tw = 1'b0;
    endtask

    // driver: expected state after the coming edge
    task automatic step(input logic e_irq, input logic [3:0] e_id,
                        input logic [7:0] e_ier, input string tag);
        exp_t e;
        @(posedge clk);
        e.irq = e_irq;
        e.id  = e_id;
        e.ier = e_ier;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares 2 ns after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (irq !== e.irq || irq_id !== e.id || ier_rdata !== e.ier) begin
                    failures++;
                    $display("FAIL %s: irq=%b id=%b ier=%h expected irq=%b id=%b ier=%h",
                             e.tag, irq, irq_id, ier_rdata, e.irq, e.id, e.ier);
                end
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 4'h1, 8'h00, "R1 reset state");
        at_neg(); wr = 1'b1; wd = 8'hFF;
        step(1'b0, 4'h1, 8'h0F, "R1 upper bits read zero");
        at_neg(); msd = 4'b0100;
        step(1'b1, 4'h0, 8'h0F, "R4 modem change");
        at_neg(); rxl = 5'd1;
        step(1'b1, 4'h4, 8'h0F, "R5 rx over modem");
        at_neg(); lse = 4'b0010;
        step(1'b1, 4'h6, 8'h0F, "R2 line error highest");
        at_neg(); lse = '0; rxl = '0; msd = '0;
        step(1'b0, 4'h1, 8'h0F, "R3 nothing pending");
        at_neg(); te = 1'b1;
        step(1'b1, 4'h2, 8'h0F, "R6 tx empty");
        at_neg(); msd = 4'b0001;
        step(1'b1, 4'h2, 8'h0F, "R10 tx over modem");
        at_neg(); rd = 1'b1;
        step(1'b1, 4'h0, 8'h0F, "R7 read clears tx");
        at_neg(); msd = '0;
        step(1'b0, 4'h1, 8'h0F, "R7 tx stays clear");
        at_neg(); te = 1'b0;
        step(1'b0, 4'h1, 8'h0F, "R6 holding full");
        at_neg(); te = 1'b1;
        step(1'b1, 4'h2, 8'h0F, "R6 re-armed");
        at_neg(); tw = 1'b1;
        step(1'b0, 4'h1, 8'h0F, "R7 holding write clears");
        at_neg(); te = 1'b0;
        step(1'b0, 4'h1, 8'h0F, "R7 idle");
        at_neg(); fm = 1'b1; te = 1'b1; tfe = 1'b0;
        step(1'b0, 4'h1, 8'h0F, "R8 buffer not empty");
        at_neg(); tfe = 1'b1;
        step(1'b1, 4'h2, 8'h0F, "R8 both empty");
        at_neg(); rd = 1'b1;
        step(1'b0, 4'h1, 8'h0F, "R7 read clears buffered tx");
        at_neg(); rxl = 5'd3; rxt = 5'd4;
        step(1'b0, 4'h1, 8'h0F, "R9 below trigger");
        at_neg(); rxl = 5'd4;
        step(1'b1, 4'h4, 8'h0F, "R9 at trigger");
        at_neg(); rxl = 5'd9;
        step(1'b1, 4'h4, 8'h0F, "R9 above trigger");
        at_neg(); rxl = 5'd3;
        step(1'b0, 4'h1, 8'h0F, "R9 drops below");
        at_neg(); fm = 1'b0;
        step(1'b1, 4'h4, 8'h0F, "R5 plain mode any byte");
        at_neg(); rxl = '0; msd = 4'b1000;
        step(1'b1, 4'h0, 8'h0F, "R4 modem bit 3");
        at_neg(); wr = 1'b1; wd = 8'h07;
        step(1'b0, 4'h1, 8'h07, "R11 modem masked");
        at_neg(); lse = 4'b1000; wr = 1'b1; wd = 8'h03;
        step(1'b0, 4'h1, 8'h03, "R11 line masked");
        at_neg(); wr = 1'b1; wd = 8'hF1;
        step(1'b0, 4'h1, 8'h01, "R11 tx masked");
        at_neg(); wr = 1'b1; wd = 8'h02;
        step(1'b0, 4'h1, 8'h02, "R6 enable edge");
        at_neg();
        step(1'b1, 4'h2, 8'h02, "R6 set after enable");
        at_neg();
        step(1'b1, 4'h2, 8'h02, "R6 held");
        repeat (3) @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule